// File: doc/BRIEF.md
# Sectioned Carry-Lookahead Adder

This block adds two unsigned N-bit operands and a single carry-in, returning an N-bit sum and a carry-out. The operand width is divided into equal sections of K bits. Inside every section each bit position forms a generate term (both operand bits set) and a propagate term (either operand bit set). These terms are folded into one section generate and one section propagate. The carry then crosses each section boundary through a single AND/OR step instead of rippling through all K bit positions.

The sum bits inside a section still come from a chain of full adders. That chain starts from the carry entering the section. The carry leaving every section is brought out on its own port, so a parent design or a bench can observe each boundary carry directly. The block has no storage, clock or reset: every output is a pure function of the present inputs. The width must be a whole multiple of the section size, and any other setting is refused when the design is elaborated.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low N bits of the arithmetic value `op_a + op_b + carry_in`, with the operands read as unsigned numbers.
- R2: `carry_out` equals bit N of the (N+1)-bit value `op_a + op_b + carry_in`.
- R3: Bit s of `sect_carry` (section s covers operand bits s*K to s*K+K-1, and section 0 receives `carry_in`) equals bit (s+1)*K of the value formed by adding the low (s+1)*K bits of both operands and `carry_in`.
- R4: When a section contains a bit position with both operand bits at 1, and every higher bit in that section has at least one operand bit at 1, that section's boundary carry is 1 whatever carry enters the section.
- R5: When every operand bit of a section is 0, that section's boundary carry is 0 even when the carry entering the section is 1.
- R6: When every bit position of a section has exactly one operand bit at 1, the section's boundary carry equals the carry entering it, for an entering carry of both 0 and 1.
- R7: `carry_out` always equals the most significant bit of `sect_carry`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N (32) | First unsigned operand |
| op_b | input | N (32) | Second unsigned operand |
| carry_in | input | 1 | Carry into the least significant bit |
| sum | output | N (32) | Low N bits of the total |
| carry_out | output | 1 | Carry out of the most significant bit |
| sect_carry | output | N/K (8) | Carry leaving each section, bit s for section s |

## Verification
Every result is due in the same cycle as its stimulus, zero clock edges later, because no register lies on any path. The bench therefore changes the operands on the falling clock edge and samples all outputs a fixed 2 ns later, well inside the half period and away from the rising edge. This gives the combinational paths time to settle before any comparison. The expected sum, carry-out and every section carry are recomputed in the bench from masked 64-bit additions for each vector.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Bit-level generate: a carry is created here regardless of the incoming one.
  function automatic logic bit_gen(input logic a, input logic b);
    return a & b;
  endfunction

  // Bit-level propagate: an incoming carry would be passed upward.
  function automatic logic bit_prop(input logic a, input logic b);
    return a | b;
  endfunction

  // One AND/OR step: carry leaving a bit or a group.
  function automatic logic carry_step(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

  // Sum bit of a full adder.
  function automatic logic sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

endpackage

// File: rtl/cla_pg_unit.sv
module cla_pg_unit #(
  parameter int K = 4
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  output logic [K-1:0] g,
  output logic [K-1:0] p
);
  import cla_pkg::*;

  for (genvar i = 0; i < K; i++) begin : g_bit
    assign g[i] = bit_gen(a[i], b[i]);
    assign p[i] = bit_prop(a[i], b[i]);
  end

endmodule

// File: rtl/cla_group_reduce.sv
module cla_group_reduce #(
  parameter int K = 4
) (
  input  logic [K-1:0] g,
  input  logic [K-1:0] p,
  output logic         grp_g,
  output logic         grp_p
);
  import cla_pkg::*;

  always_comb begin
    logic acc_g;
    logic acc_p;
    acc_g = 1'b0;
    acc_p = 1'b1;
    // Fold from the low bit upward: G = g[top] + p[top](... + p[1] g[0])
    for (int i = 0; i < K; i++) begin
      acc_g = carry_step(g[i], p[i], acc_g);
      acc_p = acc_p & p[i];
    end
    grp_g = acc_g;
    grp_p = acc_p;
  end

endmodule

// File: rtl/cla_ripple_sum.sv
module cla_ripple_sum #(
  parameter int K = 4
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  input  logic [K-1:0] g,
  input  logic [K-1:0] p,
  input  logic         c_in,
  output logic [K-1:0] s,
  output logic         ripple_co
);
  import cla_pkg::*;

  always_comb begin
    logic c;
    c = c_in;
    for (int i = 0; i < K; i++) begin
      s[i] = sum_bit(a[i], b[i], c);
      c    = carry_step(g[i], p[i], c);
    end
    ripple_co = c;
  end

endmodule

// File: rtl/cla_section.sv
module cla_section #(
  parameter int K = 4
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  input  logic         c_in,
  output logic [K-1:0] s,
  output logic         c_out
);
  import cla_pkg::*;

  logic [K-1:0] g;
  logic [K-1:0] p;
  logic         grp_g;
  logic         grp_p;
  logic         ripple_co;   // carry from the in-section chain, used only for checking

  cla_pg_unit #(.K(K)) i_pg (
    .a (a),
    .b (b),
    .g (g),
    .p (p)
  );

  cla_group_reduce #(.K(K)) i_reduce (
    .g     (g),
    .p     (p),
    .grp_g (grp_g),
    .grp_p (grp_p)
  );

  cla_ripple_sum #(.K(K)) i_ripple (
    .a         (a),
    .b         (b),
    .g         (g),
    .p         (p),
    .c_in      (c_in),
    .s         (s),
    .ripple_co (ripple_co)
  );

  // Lookahead carry across the section: one AND/OR step.
  assign c_out = carry_step(grp_g, grp_p, c_in);

  always_comb begin
    // R3: the skip carry must agree with the carry the sum chain produces
    a_r3_skip_matches_ripple: assert (c_out == ripple_co)
      else $error("section skip carry %b differs from ripple carry %b", c_out, ripple_co);
    // R4: a section that generates forces its carry out high
    if (grp_g) begin
      a_r4_generate_forces_carry: assert (c_out)
        else $error("section generates but carry out is 0");
    end
    // R5: a section that neither generates nor propagates kills the carry
    if (!grp_g && !grp_p) begin
      a_r5_kill_clears_carry: assert (!c_out)
        else $error("section kills but carry out is 1");
    end
    // R6: a pure-propagate section forwards its incoming carry
    if (grp_p && !grp_g) begin
      a_r6_propagate_forwards: assert (c_out == c_in)
        else $error("propagating section output %b, input %b", c_out, c_in);
    end
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int N = 32,
  parameter int K = 4
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  input  logic           carry_in,
  output logic [N-1:0]   sum,
  output logic           carry_out,
  output logic [N/K-1:0] sect_carry
);

  localparam int NSEC = N / K;

  if ((N % K) != 0 || K < 1) begin : g_bad_split
    $error("cla_adder: width %0d is not a whole multiple of section size %0d", N, K);
  end

  // chain[s] is the carry entering section s; chain[NSEC] leaves the block
  logic [NSEC:0] chain;
  assign chain[0] = carry_in;

  for (genvar s = 0; s < NSEC; s++) begin : g_sect
    cla_section #(.K(K)) i_section (
      .a     (op_a[s*K +: K]),
      .b     (op_b[s*K +: K]),
      .c_in  (chain[s]),
      .s     (sum[s*K +: K]),
      .c_out (chain[s+1])
    );
  end

  assign sect_carry = chain[NSEC:1];
  assign carry_out  = chain[NSEC];

  always_comb begin
    // R1 and R2: the full (N+1)-bit result matches plain addition
    a_r1_r2_total_matches: assert ({carry_out, sum} ==
                                   ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, carry_in}))
      else $error("adder result %h_%h does not match arithmetic total", carry_out, sum);
  end

endmodule

// File: tb/test_cla_adder.sv
module test_cla_adder;

  localparam int N    = 32;
  localparam int K    = 4;
  localparam int NSEC = N / K;

  logic          clk;
  logic          rst;
  logic [N-1:0]  op_a;
  logic [N-1:0]  op_b;
  logic          carry_in;
  logic [N-1:0]  sum;
  logic          carry_out;
  logic [NSEC-1:0] sect_carry;

  int n_checks;
  int n_fail;
  bit finished;

  cla_adder #(.N(N), .K(K)) i_cla_adder (
    .op_a       (op_a),
    .op_b       (op_b),
    .carry_in   (carry_in),
    .sum        (sum),
    .carry_out  (carry_out),
    .sect_carry (sect_carry)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bench reference: carry leaving bit w-1 of a masked addition
  function automatic logic ref_carry_at(input logic [N-1:0] a, input logic [N-1:0] b,
                                        input logic c, input int w);
    logic [63:0] m;
    logic [63:0] t;
    m = (64'd1 << w) - 64'd1;
    t = ({32'd0, a} & m) + ({32'd0, b} & m) + {63'd0, c};
    return t[w];
  endfunction

  function automatic logic [N-1:0] ref_sum(input logic [N-1:0] a, input logic [N-1:0] b,
                                           input logic c);
    logic [63:0] t;
    t = {32'd0, a} + {32'd0, b} + {63'd0, c};
    return t[N-1:0];
  endfunction

  task automatic check1(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic c);
    @(negedge clk);
    op_a = a;
    op_b = b;
    carry_in = c;
    #2;
  endtask

  // Full check of one vector: R1, R2, R3, R7
  task automatic apply_full(input logic [N-1:0] a, input logic [N-1:0] b, input logic c);
    logic [N-1:0] es;
    drive(a, b, c);
    es = ref_sum(a, b, c);
    n_checks++;
    if (sum !== es) begin
      n_fail++;
      $display("FAIL R1 sum a=%h b=%h c=%b: actual %h expected %h", a, b, c, sum, es);
    end
    check1(carry_out, ref_carry_at(a, b, c, N), "R2", "carry_out");
    for (int s = 0; s < NSEC; s++) begin
      check1(sect_carry[s], ref_carry_at(a, b, c, (s+1)*K), "R3", $sformatf("sect_carry[%0d]", s));
    end
    check1(carry_out, sect_carry[NSEC-1], "R7", "carry_out vs top section carry");
  endtask

  initial begin
    int wd;
    wd = 0;
    @(posedge rst);
    forever begin
      @(posedge clk);
      wd++;
      if (finished) break;
      if (wd > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    op_a = '0;
    op_b = '0;
    carry_in = 1'b0;
    rst = 1'b0;
    #1 rst = 1'b1;
    void'($urandom(32'd24681));

    // Quiet state: zero plus zero gives zero everywhere (R1, R2, R3)
    apply_full(32'h0, 32'h0, 1'b0);
    // All ones plus carry-in wraps to zero with carry out (R1, R2)
    apply_full(32'hFFFF_FFFF, 32'h0, 1'b1);
    apply_full(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply_full(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    apply_full(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    apply_full(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
    apply_full(32'h8000_0000, 32'h8000_0000, 1'b0);
    apply_full(32'h0000_000F, 32'h0000_0001, 1'b0);

    // R4: section 1 (bits 7:4) has a=b=F -> generate; entering carry 0 and 1
    drive(32'h0000_00F0, 32'h0000_00F0, 1'b0);
    check1(sect_carry[1], 1'b1, "R4", "generate, entering 0");
    drive(32'h0000_00FF, 32'h0000_00F0, 1'b1);
    check1(sect_carry[1], 1'b1, "R4", "generate, entering 1");
    // R4: generate in the low bit, propagate above (a=1,b=F in section 2)
    drive(32'h0000_0100, 32'h0000_0F00, 1'b0);
    check1(sect_carry[2], 1'b1, "R4", "low generate propagated");

    // R5: section 2 all zero while carry 1 enters from sections 0..1
    drive(32'h0000_00FF, 32'h0000_0000, 1'b1);
    check1(sect_carry[1], 1'b1, "R5", "entering carry is 1");
    check1(sect_carry[2], 1'b0, "R5", "zero section kills carry");
    check1(carry_out, 1'b0, "R5", "no carry beyond killed section");

    // R6: section 3 (bits 15:12) a=A, b=5; entering carry forced 1 then 0
    drive(32'h0000_AFFF, 32'h0000_5000, 1'b1);
    check1(sect_carry[2], 1'b1, "R6", "entering carry is 1");
    check1(sect_carry[3], 1'b1, "R6", "propagate forwards 1");
    drive(32'h0000_AFFF, 32'h0000_5000, 1'b0);
    check1(sect_carry[2], 1'b0, "R6", "entering carry is 0");
    check1(sect_carry[3], 1'b0, "R6", "propagate forwards 0");
    // R6: whole word propagates; carry_in passes to carry_out
    drive(32'h5A5A_A5A5, 32'hA5A5_5A5A, 1'b1);
    check1(carry_out, 1'b1, "R6", "full-width propagate, carry_in 1");

    // Random vectors against the bench reference
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] ra;
      logic [N-1:0] rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 5 == 0) rb = ~ra;
      apply_full(ra, rb, 1'($urandom() & 1));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule